// File: doc/BRIEF.md
# Pointer-Tracking Byte Bus Memory Slave

This block is a memory slave for an 8-bit multiplexed bus. The bus never carries an address alongside each access. Every attached device keeps its own 16-bit pointer and builds it from a pair of address-load cycles. The low byte arrives first and the high byte second. Each read or write cycle then uses the pointer, and the pointer steps forward by one after every access. The slave compares its pointer with a parameterised window. When the pointer lies inside the window, the slave serves reads from a small internal RAM and stores written bytes into it.

Bus cycles are framed by a phase-1 qualifier. The strobes of a cycle are taken when phase 1 rises. A read byte is driven while phase 1 is high. Every receiver captures the bus byte on the falling edge of phase 1.

A load strobe and a read strobe may occur in the same cycle. In that cycle the slave that owns the current pointer supplies the byte, and every device also takes that same byte as its next address byte. A cycle with no strobe leaves all state alone. An undriven bus floats high, so the slave presents 0xFF whenever it is not driving.

Top module: `mbs_slave`

## Requirements
- R1: After reset, `data_oe` is 0 and `data_out` is 0xFF. Until a full two-byte address has been loaded, no read is answered.
- R2: An address is formed from two load cycles: the byte sampled in the first is bits 7:0 and the byte sampled in the second is bits 15:8. A read that follows returns the RAM byte stored at that address.
- R3: After only the low byte of a new address has been loaded, the previous pointer stays in force for reads and writes. The new address replaces it only when the high byte is loaded.
- R4: Consecutive reads with no new address return the bytes at consecutive addresses.
- R5: A write cycle stores the byte sampled at the phase-1 fall at the current pointer when the pointer is in the window. It then advances the pointer by one.
- R6: In a cycle with both load and read strobes, the slave drives the byte at its current pointer and also takes that same byte as the next address byte. The pointer still advances unless that byte completes an address.
- R7: A cycle with no strobe changes neither the pointer nor the bus: `data_oe` stays 0.
- R8: When the pointer is outside the window [BASE, BASE+DEPTH), reads are not driven, so the bus reads 0xFF and `data_out` is 0xFF. Writes there leave the RAM unchanged.
- R9: The pointer advances from 0xFFFF to 0x0000.
- R10: `data_oe` rises only in a cycle with the read strobe low and phase 1 high. It is low again in the clock after phase 1 falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ph1 | input | 1 | Phase-1 qualifier, high during the data phase of a bus cycle |
| lma_n | input | 1 | Active-low address-load strobe |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| data_in | input | 8 | Resolved bus byte as seen by this slave |
| data_out | output | 8 | Byte this slave drives, 0xFF when idle |
| data_oe | output | 1 | High while this slave drives the bus |

## Verification
The bench builds the slave with a window at BASE = 0x0000 and DEPTH = 32. With the window at the bottom of the address space, a pointer that advances past 0xFFFF lands on a readable byte, so wrap-around shows up directly at the bus. Addresses 0x0020 and 0x0021 sit just past the window and alias RAM indices 0 and 1 if the decode were only truncated. Writing there and reading index 0 and 1 back exposes a faulty range check. Shared load-and-read cycles are exercised with RAM contents that themselves form a valid in-window address. The committed pointer is then visible through an ordinary read.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef struct packed {
    logic load;
    logic rd;
    logic wr;
  } strobe_t;

  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

endpackage

// File: rtl/mbs_phase.sv
module mbs_phase
  import mbs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ph1,
  input  logic    lma_n,
  input  logic    rd_n,
  input  logic    wr_n,
  output logic    rise,
  output logic    fall,
  output strobe_t strb
);

  logic ph1_q;

  assign rise = ph1 & ~ph1_q;
  assign fall = ~ph1 & ph1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph1_q <= 1'b0;
      strb  <= '0;
    end else begin
      ph1_q <= ph1;
      if (rise) begin
        strb.load <= ~lma_n;
        strb.rd   <= ~rd_n;
        strb.wr   <= ~wr_n;
      end
    end
  end

endmodule

// File: rtl/mbs_pointer.sv
module mbs_pointer
  import mbs_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall,
  input  strobe_t       strb,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] ptr,
  output logic          valid
);

  logic [DW-1:0] lo_stage;
  logic          hi_next;
  logic          commit;
  logic          step;

  assign commit = fall & strb.load & hi_next;
  assign step   = fall & (strb.rd | strb.wr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      valid    <= 1'b0;
      lo_stage <= '0;
      hi_next  <= 1'b0;
    end else begin
      if (fall && strb.load) begin
        if (!hi_next) begin
          lo_stage <= din;
          hi_next  <= 1'b1;
        end else begin
          hi_next  <= 1'b0;
        end
      end
      if (commit) begin
        ptr   <= {din, lo_stage};
        valid <= 1'b1;
      end else if (step) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mbs_window.sv
module mbs_window #(
  parameter int AW    = 16,
  parameter int BASE  = 0,
  parameter int DEPTH = 32,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [AW-1:0] ptr,
  input  logic          valid,
  output logic          hit,
  output logic [IW-1:0] idx
);

  localparam logic [AW:0] LO_B = (AW+1)'(BASE);
  localparam logic [AW:0] HI_B = (AW+1)'(BASE + DEPTH);

  logic [AW:0] ptr_x;

  assign ptr_x = {1'b0, ptr};
  assign hit   = valid && (ptr_x >= LO_B) && (ptr_x < HI_B);
  assign idx   = IW'(ptr - AW'(BASE));

endmodule

// File: rtl/mbs_store.sv
module mbs_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/mbs_slave.sv
module mbs_slave
  import mbs_pkg::*;
#(
  parameter int DW    = 8,
  parameter int BASE  = 'h8000,
  parameter int DEPTH = 256,
  localparam int AW = 2 * DW,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ph1,
  input  logic          lma_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe
);

  logic          rise;
  logic          fall;
  strobe_t       strb;
  logic [AW-1:0] ptr;
  logic          valid;
  logic          hit;
  logic [IW-1:0] idx;
  logic [DW-1:0] ram_q;
  logic          rd_go;
  logic          wr_go;

  mbs_phase u_phase (
    .clk   (clk),
    .rst   (rst),
    .ph1   (ph1),
    .lma_n (lma_n),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .rise  (rise),
    .fall  (fall),
    .strb  (strb)
  );

  mbs_pointer #(.DW(DW)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .fall  (fall),
    .strb  (strb),
    .din   (data_in),
    .ptr   (ptr),
    .valid (valid)
  );

  mbs_window #(.AW(AW), .BASE(BASE), .DEPTH(DEPTH)) u_win (
    .ptr   (ptr),
    .valid (valid),
    .hit   (hit),
    .idx   (idx)
  );

  assign rd_go = rise & ~rd_n & hit;
  assign wr_go = fall & strb.wr & hit;

  mbs_store #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_go),
    .waddr (idx),
    .wdata (data_in),
    .re    (rd_go),
    .raddr (idx),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe <= 1'b0;
    end else if (fall) begin
      data_oe <= 1'b0;
    end else if (rise) begin
      data_oe <= rd_go;
    end
  end

  assign data_out = data_oe ? ram_q : {DW{1'b1}};

endmodule

// File: rtl/mbs_slave_chk.sv
module mbs_slave_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ph1,
  input logic          rd_n,
  input logic [DW-1:0] data_out,
  input logic          data_oe
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !data_oe);

  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> data_out == {DW{1'b1}});

  // R10
  drop_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ph1) |=> !data_oe);

  // R7
  rise_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_oe) |-> ($past(rd_n) == 1'b0) && $past(ph1));

  // R10
  drive_in_phase_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> $past(ph1));

endmodule

bind mbs_slave mbs_slave_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ph1      (ph1),
  .rd_n     (rd_n),
  .data_out (data_out),
  .data_oe  (data_oe)
);

// File: tb/mbs_slave_tb.sv
`timescale 1ns/1ps
module mbs_slave_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ph1 = 1'b0;
  logic       lma_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       ext_en = 1'b0;
  logic [7:0] ext_val = 8'h00;
  logic [7:0] data_in;
  logic [7:0] data_out;
  logic       data_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  event  smp;

  always #2.5 clk = ~clk;

  assign data_in = data_oe ? data_out : (ext_en ? ext_val : 8'hFF);

  mbs_slave #(.DW(8), .BASE(0), .DEPTH(32)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .ph1      (ph1),
    .lma_n    (lma_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .data_in  (data_in),
    .data_out (data_out),
    .data_oe  (data_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected bus bytes and compares with the resolved bus
  initial begin
    forever begin
      @(smp);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(data_in === it.exp, it.tag, data_in, it.exp);
      end
    end
  end

  task automatic cyc(input bit l, input bit r, input bit w, input bit xen,
                     input logic [7:0] xv, input bit chk, input logic [7:0] exp,
                     input string tag);
    @(negedge clk);
    lma_n = ~l; rd_n = ~r; wr_n = ~w; ext_en = xen; ext_val = xv;
    @(negedge clk);
    ph1 = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (chk) begin
      sb_q.push_back('{exp, tag});
      ->smp;
    end
    ph1 = 1'b0;
    @(negedge clk);
    if (r) check(data_oe == 1'b0, "R10 oe after fall", {7'b0, data_oe}, 8'h00);
    lma_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ext_en = 1'b0;
  endtask

  task automatic load(input logic [15:0] a);
    cyc(1, 0, 0, 1, a[7:0], 0, 8'h00, "");
    cyc(1, 0, 0, 1, a[15:8], 0, 8'h00, "");
  endtask

  task automatic wbyte(input logic [7:0] d);
    cyc(0, 0, 1, 1, d, 0, 8'h00, "");
  endtask

  task automatic rbyte(input logic [7:0] exp, input string tag);
    cyc(0, 1, 0, 0, 8'h00, 1, exp, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(data_oe == 1'b0, "R1 oe at reset", {7'b0, data_oe}, 8'h00);
    check(data_out == 8'hFF, "R1 data_out at reset", data_out, 8'hFF);
    rbyte(8'hFF, "R1 read before address");

    // R5 writes with advance
    load(16'h0000);
    wbyte(8'h5A); wbyte(8'h5B);
    load(16'h0004);
    wbyte(8'h06); wbyte(8'h00); wbyte(8'h33);

    // R2 / R4 sequential reads
    load(16'h0004);
    rbyte(8'h06, "R2 read at loaded address");
    rbyte(8'h00, "R4 next byte");
    rbyte(8'h33, "R4 third byte");

    // R7 idle cycle
    load(16'h0005);
    cyc(0, 0, 0, 0, 8'h00, 1, 8'hFF, "R7 idle bus undriven");
    rbyte(8'h00, "R7 pointer kept over idle");

    // R3 partial load keeps old pointer
    load(16'h0004);
    cyc(1, 0, 0, 1, 8'h06, 0, 8'h00, "");
    rbyte(8'h06, "R3 old pointer after low byte");
    cyc(1, 0, 0, 1, 8'h00, 0, 8'h00, "");
    rbyte(8'h33, "R3 new pointer after high byte");

    // R6 shared load and read
    load(16'h0004);
    cyc(1, 1, 0, 0, 8'h00, 1, 8'h06, "R6 shared cycle low byte");
    cyc(1, 1, 0, 0, 8'h00, 1, 8'h00, "R6 shared cycle high byte");
    rbyte(8'h33, "R6 pointer from shared bytes");

    // R8 outside window
    load(16'h0020);
    rbyte(8'hFF, "R8 read outside window");
    wbyte(8'hAA);
    wbyte(8'hAB);
    load(16'h0000);
    rbyte(8'h5A, "R8 ram kept idx0");
    rbyte(8'h5B, "R8 ram kept idx1");

    // R9 wrap
    load(16'hFFFF);
    rbyte(8'hFF, "R9 read at FFFF outside");
    rbyte(8'h5A, "R9 wrapped to 0000");
    rbyte(8'h5B, "R9 then 0001");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule